// File: doc/BRIEF.md
# UART line status tracker

This block holds the line status byte of a single-channel UART and drives its line status interrupt. The receive path reports each completed character with a one-cycle strobe. The strobe carries a parity-error qualifier and a stop-bit (framing) error qualifier. The block also watches the received line level so that it can detect a break. The transmit path reports three events with single-cycle strobes: the host writing the holding register, the holding register moving into the shift register, and the shift register finishing.

Break detection counts baud bit ticks while the receive line is low. It compares that count with a programmable frame length given in ticks. The error flags latch and are cleared by a status read, so the host always sees the errors that belong to the character waiting to be read. The transmit flags report two states separately: when the holding register can take a new byte, and when the whole transmitter is idle. The serializer, deserializer and baud generator sit outside this block.

Top module: `uart_lsr_tracker`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `lsr_byte` is 8'h60 (bits 5 and 6 set, all others clear) and `line_irq` is 0.
- R2: Bit 0 (data ready) is 1 after the clock edge that samples `rx_strobe`. It is 0 after an edge that samples `rhr_read` without `rx_strobe`. When both are sampled on the same edge, the bit ends up 1.
- R3: Bit 2 (parity error) is 1 after an edge that samples `rx_strobe` with `rx_parity_err`. It stays set across later clean characters. It is 0 after an edge that samples `lsr_read` with no new parity event. A new parity event on the same edge as a read leaves the bit at 1.
- R4: Bit 3 (framing error) follows the same set, hold and clear rules as R3, using `rx_frame_err` as the qualifier.
- R5: Bit 4 (break) is 1 after the edge on which the count of `bit_tick` pulses, seen while `rx_line` stays 0, reaches `frame_ticks`. Any cycle with `rx_line` at 1 restarts the count. A `frame_ticks` value of 0 disables detection.
- R6: In the default mode, bit 4 stays set for as long as `rx_line` is 0, whatever reads arrive. Once `rx_line` is 1, an edge that samples `lsr_read` clears it. A new detection on the same edge takes priority over the clear.
- R7: Bit 5 (holding register empty) is 0 after an edge that samples `thr_write`. It is 1 after an edge that samples `thr_to_tsr` without `thr_write`. When both are sampled on the same edge, the bit is 0.
- R8: Bit 6 (transmitter idle) is 1 only when bit 5 is 1 and the shift register is empty. The shift register becomes full on `thr_to_tsr`. It becomes empty on `tsr_done` unless `thr_to_tsr` arrives on the same edge.
- R9: `line_irq` equals `lsi_enable` AND (bit 2 OR bit 3 OR bit 4), and it follows `lsi_enable` within the same cycle.
- R10: Bits 1 and 7 of `lsr_byte` always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | One pulse per received bit period |
| rx_line | input | 1 | Synchronized receive line level (1 = mark) |
| frame_ticks | input | TICK_W | Frame length in bit ticks for break detection |
| rx_strobe | input | 1 | A received character is now in the read register |
| rx_parity_err | input | 1 | Qualifier: that character had bad parity |
| rx_frame_err | input | 1 | Qualifier: that character lacked a valid stop bit |
| rhr_read | input | 1 | Host reads the received character |
| lsr_read | input | 1 | Host reads the status byte |
| thr_write | input | 1 | Host writes the transmit holding register |
| thr_to_tsr | input | 1 | Holding register moves into the shift register |
| tsr_done | input | 1 | Shift register has sent its last bit |
| lsi_enable | input | 1 | Line status interrupt enable |
| lsr_byte | output | 8 | Line status byte |
| line_irq | output | 1 | Line status interrupt request |

## Verification
Every status bit is registered. The bench applies an event on a falling edge, and the design captures it on the next rising edge. The result is then due one half-period later, and the bench compares it on the following falling edge. `line_irq` is combinational from the status register and `lsi_enable`, so it is compared in the same half-cycle, against the status bits of that cycle. A break needs `frame_ticks` ticks. Its flag is expected after the rising edge that samples the last of those ticks, never earlier. A reference model in the bench is advanced on each rising edge from the same inputs, so every cycle, random or directed, is checked at the same point.

// File: rtl/uart_lsr_pkg.sv
package uart_lsr_pkg;

   // Bit positions in the status byte that software decodes
   localparam int unsigned LSR_W       = 8;
   localparam int unsigned BIT_READY   = 0;
   localparam int unsigned BIT_PARITY  = 2;
   localparam int unsigned BIT_FRAMING = 3;
   localparam int unsigned BIT_BREAK   = 4;
   localparam int unsigned BIT_TXHOLD  = 5;
   localparam int unsigned BIT_TXIDLE  = 6;

   typedef struct packed {
      logic rsvd7;
      logic tx_idle;
      logic tx_hold_empty;
      logic brk;
      logic framing;
      logic parity;
      logic rsvd1;
      logic ready;
   } lsr_t;

   // Break flag release policies
   typedef enum logic {
      BRK_CLEAR_ON_READ = 1'b0,
      BRK_CLEAR_AT_MARK = 1'b1
   } brk_mode_e;

endpackage

// File: rtl/uart_sticky_flag.sv
module uart_sticky_flag #(
   parameter bit RESET_VAL = 1'b0,
   parameter bit SET_WINS  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_o <= RESET_VAL;
      end else if (set_i && clr_i) begin
         flag_o <= SET_WINS;
      end else if (set_i) begin
         flag_o <= 1'b1;
      end else if (clr_i) begin
         flag_o <= 1'b0;
      end
   end

endmodule

// File: rtl/uart_break_det.sv
module uart_break_det
   import uart_lsr_pkg::*;
#(
   parameter int unsigned TICK_W   = 8,
   parameter brk_mode_e   CLR_MODE = BRK_CLEAR_ON_READ
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_tick,
   input  logic              rx_line,
   input  logic [TICK_W-1:0] frame_ticks,
   input  logic              lsr_read,
   output logic              brk_o
);

   logic [TICK_W-1:0] low_cnt;
   logic              at_limit;
   logic              hit;
   logic              release_req;

   assign at_limit = (low_cnt == frame_ticks);
   assign hit      = !rx_line && bit_tick && (frame_ticks != '0)
                     && (low_cnt == frame_ticks - 1'b1);

   // Count ticks of continuous space; saturate at the frame length
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt <= '0;
      end else if (rx_line) begin
         low_cnt <= '0;
      end else if (bit_tick && !at_limit) begin
         low_cnt <= low_cnt + 1'b1;
      end
   end

   generate
      if (CLR_MODE == BRK_CLEAR_AT_MARK) begin : g_auto_release
         assign release_req = rx_line;
      end else begin : g_read_release
         assign release_req = rx_line && lsr_read;
      end
   endgenerate

   uart_sticky_flag #(
      .RESET_VAL (1'b0),
      .SET_WINS  (1'b1)
   ) u_brk_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (hit),
      .clr_i  (release_req),
      .flag_o (brk_o)
   );

endmodule

// File: rtl/uart_tx_flags.sv
module uart_tx_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic thr_write,
   input  logic thr_to_tsr,
   input  logic tsr_done,
   output logic hold_empty_o,
   output logic tx_idle_o
);

   logic shifter_busy;

   // Host write beats a same-cycle transfer: the holding register is refilled
   uart_sticky_flag #(
      .RESET_VAL (1'b1),
      .SET_WINS  (1'b0)
   ) u_hold_empty (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (thr_to_tsr),
      .clr_i  (thr_write),
      .flag_o (hold_empty_o)
   );

   // A new transfer beats a same-cycle completion: the shifter is reloaded
   uart_sticky_flag #(
      .RESET_VAL (1'b0),
      .SET_WINS  (1'b1)
   ) u_shift_busy (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (thr_to_tsr),
      .clr_i  (tsr_done),
      .flag_o (shifter_busy)
   );

   assign tx_idle_o = hold_empty_o && !shifter_busy;

endmodule

// File: rtl/uart_lsr_tracker.sv
module uart_lsr_tracker
   import uart_lsr_pkg::*;
#(
   parameter int unsigned TICK_W   = 8,
   parameter brk_mode_e   BRK_MODE = BRK_CLEAR_ON_READ
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_tick,
   input  logic              rx_line,
   input  logic [TICK_W-1:0] frame_ticks,
   input  logic              rx_strobe,
   input  logic              rx_parity_err,
   input  logic              rx_frame_err,
   input  logic              rhr_read,
   input  logic              lsr_read,
   input  logic              thr_write,
   input  logic              thr_to_tsr,
   input  logic              tsr_done,
   input  logic              lsi_enable,
   output logic [7:0]        lsr_byte,
   output logic              line_irq
);

   localparam int unsigned N_RX_FLAGS = 3;   // ready, parity, framing

   generate
      if (TICK_W < 2 || TICK_W > 24) begin : g_bad_tick_w
         $error("uart_lsr_tracker: TICK_W must lie in 2..24");
      end
   endgenerate

   lsr_t              st;
   logic [N_RX_FLAGS-1:0] rx_set;
   logic [N_RX_FLAGS-1:0] rx_clr;
   logic [N_RX_FLAGS-1:0] rx_q;
   logic              brk_q;
   logic              hold_empty_q;
   logic              tx_idle_q;

   // Data ready clears on a character read; the error flags clear on a status read
   assign rx_set = {rx_strobe && rx_frame_err, rx_strobe && rx_parity_err, rx_strobe};
   assign rx_clr = {lsr_read, lsr_read, rhr_read};

   generate
      for (genvar gi = 0; gi < N_RX_FLAGS; gi++) begin : g_rx_flag
         uart_sticky_flag #(
            .RESET_VAL (1'b0),
            .SET_WINS  (1'b1)
         ) u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (rx_set[gi]),
            .clr_i  (rx_clr[gi]),
            .flag_o (rx_q[gi])
         );
      end
   endgenerate

   uart_break_det #(
      .TICK_W   (TICK_W),
      .CLR_MODE (BRK_MODE)
   ) u_break (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_tick    (bit_tick),
      .rx_line     (rx_line),
      .frame_ticks (frame_ticks),
      .lsr_read    (lsr_read),
      .brk_o       (brk_q)
   );

   uart_tx_flags u_tx (
      .clk          (clk),
      .rst_n        (rst_n),
      .thr_write    (thr_write),
      .thr_to_tsr   (thr_to_tsr),
      .tsr_done     (tsr_done),
      .hold_empty_o (hold_empty_q),
      .tx_idle_o    (tx_idle_q)
   );

   always_comb begin
      st               = '0;
      st.ready         = rx_q[0];
      st.parity        = rx_q[1];
      st.framing       = rx_q[2];
      st.brk           = brk_q;
      st.tx_hold_empty = hold_empty_q;
      st.tx_idle       = tx_idle_q;
   end

   assign lsr_byte = st;
   assign line_irq = lsi_enable && (st.parity || st.framing || st.brk);

endmodule

// File: rtl/uart_lsr_tracker_chk.sv
module uart_lsr_tracker_chk #(
   parameter int unsigned TICK_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bit_tick,
   input logic              rx_line,
   input logic [TICK_W-1:0] frame_ticks,
   input logic              rx_strobe,
   input logic              rx_parity_err,
   input logic              rx_frame_err,
   input logic              rhr_read,
   input logic              lsr_read,
   input logic              thr_write,
   input logic              thr_to_tsr,
   input logic              tsr_done,
   input logic              lsi_enable,
   input logic [7:0]        lsr_byte,
   input logic              line_irq
);

   a_r2_ready_set: assert property (@(posedge clk) disable iff (!rst_n)
      rx_strobe |=> lsr_byte[0]);

   a_r3_parity_set: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_strobe && rx_parity_err) |=> lsr_byte[2]);

   a_r3_parity_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (lsr_read && !rx_strobe) |=> !lsr_byte[2]);

   a_r4_framing_set: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_strobe && rx_frame_err) |=> lsr_byte[3]);

   a_r6_break_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (lsr_byte[4] && !rx_line) |=> lsr_byte[4]);

   a_r7_hold_write: assert property (@(posedge clk) disable iff (!rst_n)
      thr_write |=> !lsr_byte[5]);

   a_r7_hold_move: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_to_tsr && !thr_write) |=> lsr_byte[5]);

   a_r8_idle_implies_empty: assert property (@(posedge clk) disable iff (!rst_n)
      lsr_byte[6] |-> lsr_byte[5]);

   a_r8_idle_write: assert property (@(posedge clk) disable iff (!rst_n)
      thr_write |=> !lsr_byte[6]);

   a_r9_irq: assert property (@(posedge clk) disable iff (!rst_n)
      line_irq == (lsi_enable && (lsr_byte[2] || lsr_byte[3] || lsr_byte[4])));

   a_r10_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      (lsr_byte[7] == 1'b0) && (lsr_byte[1] == 1'b0));

endmodule

bind uart_lsr_tracker uart_lsr_tracker_chk #(.TICK_W(TICK_W)) u_chk (.*);

// File: tb/uart_lsr_tracker_test.sv
module uart_lsr_tracker_test;

   localparam int unsigned TICK_W = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bit_tick = 1'b0;
   logic              rx_line = 1'b1;
   logic [TICK_W-1:0] frame_ticks = 8'd4;
   logic              rx_strobe = 1'b0;
   logic              rx_parity_err = 1'b0;
   logic              rx_frame_err = 1'b0;
   logic              rhr_read = 1'b0;
   logic              lsr_read = 1'b0;
   logic              thr_write = 1'b0;
   logic              thr_to_tsr = 1'b0;
   logic              tsr_done = 1'b0;
   logic              lsi_enable = 1'b0;
   logic [7:0]        lsr_byte;
   logic              line_irq;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   // reference model state
   logic m_dr, m_pe, m_fe, m_bi, m_thre, m_tsr;
   int   m_cnt;

   always #5 clk = ~clk;

   uart_lsr_tracker #(.TICK_W(TICK_W)) uut (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] exp_lsr();
      return {1'b0, m_thre && !m_tsr, m_thre, m_bi, m_fe, m_pe, 1'b0, m_dr};
   endfunction

   function automatic logic exp_irq();
      return lsi_enable && (m_pe || m_fe || m_bi);
   endfunction

   task automatic model_reset();
      m_dr = 0; m_pe = 0; m_fe = 0; m_bi = 0; m_thre = 1; m_tsr = 0; m_cnt = 0;
   endtask

   task automatic model_step();
      logic hit;
      hit = !rx_line && bit_tick && (frame_ticks != 0) && (m_cnt == int'(frame_ticks) - 1);
      if (rx_line) m_cnt = 0;
      else if (bit_tick && m_cnt != int'(frame_ticks)) m_cnt++;
      m_dr   = rx_strobe ? 1'b1 : (rhr_read ? 1'b0 : m_dr);
      m_pe   = (rx_strobe && rx_parity_err) ? 1'b1 : (lsr_read ? 1'b0 : m_pe);
      m_fe   = (rx_strobe && rx_frame_err) ? 1'b1 : (lsr_read ? 1'b0 : m_fe);
      m_bi   = hit ? 1'b1 : ((lsr_read && rx_line) ? 1'b0 : m_bi);
      m_thre = thr_write ? 1'b0 : (thr_to_tsr ? 1'b1 : m_thre);
      m_tsr  = thr_to_tsr ? 1'b1 : (tsr_done ? 1'b0 : m_tsr);
   endtask

   task automatic check_all();
      logic [7:0] e;
      e = exp_lsr();
      chk("R2 ready", lsr_byte[0], e[0]);
      chk("R3 parity", lsr_byte[2], e[2]);
      chk("R4 framing", lsr_byte[3], e[3]);
      chk("R5,R6 break", lsr_byte[4], e[4]);
      chk("R7 hold empty", lsr_byte[5], e[5]);
      chk("R8 tx idle", lsr_byte[6], e[6]);
      chk("R10 reserved", {lsr_byte[7], lsr_byte[1]}, 2'b00);
      chk("R9 irq", line_irq, exp_irq());
   endtask

   task automatic idle_inputs();
      bit_tick = 0; rx_strobe = 0; rx_parity_err = 0; rx_frame_err = 0;
      rhr_read = 0; lsr_read = 0; thr_write = 0; thr_to_tsr = 0; tsr_done = 0;
   endtask

   // inputs are set at a falling edge before calling this
   task automatic cyc();
      @(posedge clk);
      model_step();
      @(negedge clk);
      check_all();
      idle_inputs();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int seed;
      int low_left;
      seed = 32'h5eed_1234;
      void'($urandom(seed));
      model_reset();
      repeat (3) @(negedge clk);
      // R1: values held in reset
      chk("R1 reset lsr", lsr_byte, 8'h60);
      chk("R1 reset irq", line_irq, 1'b0);
      rst_n = 1'b1;
      cyc();
      chk("R1 first cycle", lsr_byte, 8'h60);

      // R3, R2, R9: parity character, then irq follows enable at once
      rx_strobe = 1; rx_parity_err = 1; cyc();
      chk("R3 parity direct", lsr_byte[2], 1'b1);
      lsi_enable = 1; #1;
      chk("R9 irq on enable", line_irq, 1'b1);
      // R3: clean character keeps it latched
      rx_strobe = 1; cyc();
      chk("R3 hold", lsr_byte[2], 1'b1);
      // R4 and R3: status read with new framing error on the same edge
      lsr_read = 1; rx_strobe = 1; rx_frame_err = 1; cyc();
      chk("R3 cleared by read", lsr_byte[2], 1'b0);
      chk("R4 new event wins", lsr_byte[3], 1'b1);
      lsr_read = 1; cyc();
      chk("R4 cleared", lsr_byte[3], 1'b0);
      // R2: character read and arrival on the same edge
      rhr_read = 1; rx_strobe = 1; cyc();
      chk("R2 arrival wins", lsr_byte[0], 1'b1);
      rhr_read = 1; cyc();
      chk("R2 read clears", lsr_byte[0], 1'b0);

      // R5, R6: break with 4-tick frame
      frame_ticks = 8'd4; rx_line = 0;
      for (int i = 0; i < 3; i++) begin bit_tick = 1; cyc(); cyc(); end
      chk("R5 not yet", lsr_byte[4], 1'b0);
      bit_tick = 1; cyc();
      chk("R5 detected", lsr_byte[4], 1'b1);
      lsr_read = 1; cyc();
      chk("R6 held while low", lsr_byte[4], 1'b1);
      rx_line = 1; cyc();
      chk("R6 still set at mark", lsr_byte[4], 1'b1);
      lsr_read = 1; cyc();
      chk("R6 read at mark clears", lsr_byte[4], 1'b0);
      // R5: count restarts on a mark cycle
      rx_line = 0;
      for (int i = 0; i < 3; i++) begin bit_tick = 1; cyc(); end
      rx_line = 1; cyc(); rx_line = 0;
      for (int i = 0; i < 3; i++) begin bit_tick = 1; cyc(); end
      chk("R5 restart", lsr_byte[4], 1'b0);
      // R5: zero frame length disables
      frame_ticks = 8'd0;
      for (int i = 0; i < 10; i++) begin bit_tick = 1; cyc(); end
      chk("R5 disabled", lsr_byte[4], 1'b0);
      rx_line = 1; frame_ticks = 8'd4; cyc();

      // R7, R8: transmit sequence
      thr_write = 1; cyc();
      chk("R7 write clears", lsr_byte[6:5], 2'b00);
      thr_to_tsr = 1; cyc();
      chk("R8 shifting", lsr_byte[6:5], 2'b01);
      thr_write = 1; thr_to_tsr = 1; cyc();
      chk("R7 write beats move", lsr_byte[5], 1'b0);
      thr_to_tsr = 1; tsr_done = 1; cyc();
      chk("R8 reload beats done", lsr_byte[6:5], 2'b01);
      tsr_done = 1; cyc();
      chk("R8 idle", lsr_byte[6:5], 2'b11);

      // random mix
      low_left = 0;
      for (int n = 0; n < 4000; n++) begin
         if (low_left > 0) begin
            low_left--; rx_line = 0;
         end else begin
            rx_line = 1;
            if ($urandom_range(0, 40) == 0) low_left = $urandom_range(2, 60);
         end
         if (n == 2000) frame_ticks = 8'd2;
         bit_tick      = ($urandom_range(0, 3) == 0);
         rx_strobe     = ($urandom_range(0, 7) == 0);
         rx_parity_err = ($urandom_range(0, 3) == 0);
         rx_frame_err  = ($urandom_range(0, 3) == 0);
         rhr_read      = ($urandom_range(0, 5) == 0);
         lsr_read      = ($urandom_range(0, 5) == 0);
         thr_write     = ($urandom_range(0, 7) == 0);
         thr_to_tsr    = ($urandom_range(0, 7) == 0);
         tsr_done      = ($urandom_range(0, 7) == 0);
         lsi_enable    = ($urandom_range(0, 3) != 0);
         cyc();
      end

      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule